// File: doc/BRIEF.md
# Function Unit Ordering Matrix

This block keeps the ordering between in-flight instructions as a square grid of single-bit edges, one row and one column per function unit. Each cell holds two bits: one saying "this unit must wait for that unit's result before reading", and one saying "this unit must wait for that unit to finish reading before writing". The row number is the unit's identity, so no tag or sequence number is stored anywhere. Program order is kept by the edges themselves, which link each newer instruction to the older ones it depends on.

On issue, the row of the newly allocated unit is loaded from two vectors that the register tracking logic supplies: the units that still have to write a register the new instruction reads, and the units that still have to read the register it will write. When a unit finishes or is cancelled, a clear strobe wipes its column in every row and empties its own row. A unit may read its operands once no write edge is left in its row, and may write its result once no read edge is left. Both enables are a NOR across the stored row, so they follow the stored state only.

Top module: `fu_dep_matrix`

## Requirements
- R1: While reset is low and in the cycle after it, every bit of `readable` and `writable` is 1.
- R2: An accepted issue for unit u loads u's write-wait edges from `pendWriteVec`. If any such edge remains, `readable[u]` is 0 from the cycle after the issue edge.
- R3: An accepted issue for unit u loads u's read-wait edges from `pendReadVec`. If any such edge remains, `writable[u]` is 0 from the cycle after the issue edge.
- R4: Bit u of `pendWriteVec` and `pendReadVec` is ignored when unit u issues, so a unit never waits on itself.
- R5: A 1 in `goClear[j]` removes column j from every row at the next edge. Rows that waited only on j become readable or writable again.
- R6: A 1 in `goClear[j]` empties row j at the next edge, leaving unit j readable and writable, unless unit j issues in the same cycle. In that case the issue loads the row.
- R7: When a unit issues in the same cycle as `goClear[j]`, its new row gets no edge to unit j.
- R8: An issue is accepted only when `issueValid` is 1 and `issueUnit` has exactly one bit set. Any other `issueUnit` pattern leaves the matrix unchanged.
- R9: Rows that are neither issued nor cleared keep their edges, apart from the column clears of R5.
- R10: `readable` and `writable` depend only on the stored matrix. A change on the inputs shows up only after the next rising clock edge.
- R11: Any number of `goClear` bits may be set in one cycle, and each one acts as in R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset, empties the matrix |
| issueValid | input | 1 | Issue strobe |
| issueUnit | input | NUM_UNITS | One-hot identity of the unit being issued |
| pendWriteVec | input | NUM_UNITS | Units with pending writes to registers the new instruction reads |
| pendReadVec | input | NUM_UNITS | Units with pending reads of the register the new instruction writes |
| goClear | input | NUM_UNITS | Per-unit completion or cancel strobe |
| readable | output | NUM_UNITS | Per-unit: no write-wait edge remains |
| writable | output | NUM_UNITS | Per-unit: no read-wait edge remains |

## Verification
The hardest case to reach is an edge race: an issue whose hazard vectors name a unit that is being cleared in the same cycle, while the cleared unit's own row is also being wiped. This happens rarely when stimulus is left to chance. The bench therefore builds a dependency chain in directed steps and then issues against a unit at the moment it is cleared. The random phase then sets `goClear` densely and allows several clear bits at once, so that clears, reloads and malformed issue patterns meet often. Expected enables come from a bench model of the edge grid and are compared on every cycle, both just before and just after each edge.

// File: rtl/fudm_pkg.sv
package fudm_pkg;
  // Per-row command from the control half to the storage half.
  typedef struct packed {
    logic load;   // overwrite the row with the issue vectors
    logic wipe;   // empty the row (unit finished or cancelled)
  } rowCmd_t;
endpackage

// File: rtl/fudm_ctrl.sv
module fudm_ctrl
  import fudm_pkg::*;
#(
  parameter int NUM_UNITS = 8
) (
  input  logic                 issueValid,
  input  logic [NUM_UNITS-1:0] issueUnit,
  input  logic [NUM_UNITS-1:0] pendWriteVec,
  input  logic [NUM_UNITS-1:0] pendReadVec,
  input  logic [NUM_UNITS-1:0] goClear,
  output rowCmd_t              rowCmd [NUM_UNITS],
  output logic [NUM_UNITS-1:0] loadWr,
  output logic [NUM_UNITS-1:0] loadRd,
  output logic [NUM_UNITS-1:0] colKeep
);
  localparam logic [NUM_UNITS-1:0] ONE = NUM_UNITS'(1);

  logic issueOk;
  logic [NUM_UNITS-1:0] issueRow;

  // Exactly one bit set: nonzero and no second bit.
  assign issueOk  = issueValid && (issueUnit != '0) && ((issueUnit & (issueUnit - ONE)) == '0);
  assign issueRow = issueOk ? issueUnit : '0;

  // The own column and any column being cleared this cycle never enter a new row.
  assign loadWr  = pendWriteVec & ~issueUnit & ~goClear;
  assign loadRd  = pendReadVec  & ~issueUnit & ~goClear;
  assign colKeep = ~goClear;

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_cmd
    assign rowCmd[i].load = issueRow[i];
    assign rowCmd[i].wipe = goClear[i] & ~issueRow[i];
  end
endmodule

// File: rtl/fudm_row.sv
module fudm_row
  import fudm_pkg::*;
#(
  parameter int NUM_UNITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rowCmd_t              cmd,
  input  logic [NUM_UNITS-1:0] loadWr,
  input  logic [NUM_UNITS-1:0] loadRd,
  input  logic [NUM_UNITS-1:0] colKeep,
  output logic [NUM_UNITS-1:0] wrRow,
  output logic [NUM_UNITS-1:0] rdRow
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrRow <= '0;
      rdRow <= '0;
    end else if (cmd.load) begin
      wrRow <= loadWr;
      rdRow <= loadRd;
    end else if (cmd.wipe) begin
      wrRow <= '0;
      rdRow <= '0;
    end else begin
      wrRow <= wrRow & colKeep;
      rdRow <= rdRow & colKeep;
    end
  end
endmodule

// File: rtl/fudm_array.sv
module fudm_array
  import fudm_pkg::*;
#(
  parameter int NUM_UNITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rowCmd_t              rowCmd [NUM_UNITS],
  input  logic [NUM_UNITS-1:0] loadWr,
  input  logic [NUM_UNITS-1:0] loadRd,
  input  logic [NUM_UNITS-1:0] colKeep,
  output logic [NUM_UNITS-1:0] wrMat [NUM_UNITS],
  output logic [NUM_UNITS-1:0] rdMat [NUM_UNITS]
);
  for (genvar r = 0; r < NUM_UNITS; r++) begin : g_row
    fudm_row #(.NUM_UNITS(NUM_UNITS)) u_row (
      .clk    (clk),
      .rstN   (rstN),
      .cmd    (rowCmd[r]),
      .loadWr (loadWr),
      .loadRd (loadRd),
      .colKeep(colKeep),
      .wrRow  (wrMat[r]),
      .rdRow  (rdMat[r])
    );
  end
endmodule

// File: rtl/fudm_reduce.sv
module fudm_reduce #(
  parameter int NUM_UNITS = 8
) (
  input  logic [NUM_UNITS-1:0] wrMat [NUM_UNITS],
  input  logic [NUM_UNITS-1:0] rdMat [NUM_UNITS],
  output logic [NUM_UNITS-1:0] readable,
  output logic [NUM_UNITS-1:0] writable
);
  for (genvar r = 0; r < NUM_UNITS; r++) begin : g_nor
    assign readable[r] = ~|wrMat[r];
    assign writable[r] = ~|rdMat[r];
  end
endmodule

// File: rtl/fu_dep_matrix.sv
module fu_dep_matrix
  import fudm_pkg::*;
#(
  parameter int NUM_UNITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  logic [NUM_UNITS-1:0] issueUnit,
  input  logic [NUM_UNITS-1:0] pendWriteVec,
  input  logic [NUM_UNITS-1:0] pendReadVec,
  input  logic [NUM_UNITS-1:0] goClear,
  output logic [NUM_UNITS-1:0] readable,
  output logic [NUM_UNITS-1:0] writable
);
  rowCmd_t              rowCmd [NUM_UNITS];
  logic [NUM_UNITS-1:0] loadWr, loadRd, colKeep;
  logic [NUM_UNITS-1:0] wrMat [NUM_UNITS];
  logic [NUM_UNITS-1:0] rdMat [NUM_UNITS];

  fudm_ctrl #(.NUM_UNITS(NUM_UNITS)) u_ctrl (
    .issueValid  (issueValid),
    .issueUnit   (issueUnit),
    .pendWriteVec(pendWriteVec),
    .pendReadVec (pendReadVec),
    .goClear     (goClear),
    .rowCmd      (rowCmd),
    .loadWr      (loadWr),
    .loadRd      (loadRd),
    .colKeep     (colKeep)
  );

  fudm_array #(.NUM_UNITS(NUM_UNITS)) u_array (
    .clk    (clk),
    .rstN   (rstN),
    .rowCmd (rowCmd),
    .loadWr (loadWr),
    .loadRd (loadRd),
    .colKeep(colKeep),
    .wrMat  (wrMat),
    .rdMat  (rdMat)
  );

  fudm_reduce #(.NUM_UNITS(NUM_UNITS)) u_reduce (
    .wrMat   (wrMat),
    .rdMat   (rdMat),
    .readable(readable),
    .writable(writable)
  );
endmodule

// File: rtl/fudm_checker.sv
module fudm_checker #(
  parameter int NUM_UNITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 issueValid,
  input logic [NUM_UNITS-1:0] issueUnit,
  input logic [NUM_UNITS-1:0] pendWriteVec,
  input logic [NUM_UNITS-1:0] pendReadVec,
  input logic [NUM_UNITS-1:0] goClear,
  input logic [NUM_UNITS-1:0] readable,
  input logic [NUM_UNITS-1:0] writable
);
  localparam logic [NUM_UNITS-1:0] ONE = NUM_UNITS'(1);

  logic                 okIssue;
  logic [NUM_UNITS-1:0] issuedRow;
  assign okIssue   = issueValid && (issueUnit != '0) && ((issueUnit & (issueUnit - ONE)) == '0);
  assign issuedRow = okIssue ? issueUnit : '0;

  p_reset_open_r1: assert property (@(posedge clk)
    !rstN |=> ((&readable) && (&writable)));

  p_wr_edge_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (okIssue && ((pendWriteVec & ~issueUnit & ~goClear) != '0))
      |=> ((readable & $past(issueUnit)) == '0));

  p_rd_edge_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (okIssue && ((pendReadVec & ~issueUnit & ~goClear) != '0))
      |=> ((writable & $past(issueUnit)) == '0));

  p_no_self_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    (okIssue && ((pendWriteVec & ~issueUnit) == '0) && ((pendReadVec & ~issueUnit) == '0))
      |=> (((readable & writable) & $past(issueUnit)) == $past(issueUnit)));

  p_row_wipe_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((goClear & ~issuedRow) != '0)
      |=> (($past(goClear & ~issuedRow) & ~(readable & writable)) == '0));

  p_bad_issue_r8: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !okIssue && (goClear == '0))
      |=> ($stable(readable) && $stable(writable)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!issueValid && (goClear == '0))
      |=> ($stable(readable) && $stable(writable)));
endmodule

bind fu_dep_matrix fudm_checker #(.NUM_UNITS(NUM_UNITS)) u_chk (.*);

// File: tb/fu_dep_matrix_bench.sv
module fu_dep_matrix_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         issueValid = 1'b0;
  logic [N-1:0] issueUnit = '0;
  logic [N-1:0] pendWriteVec = '0;
  logic [N-1:0] pendReadVec = '0;
  logic [N-1:0] goClear = '0;
  logic [N-1:0] readable, writable;

  int vecCount = 0;
  int missCount = 0;
  bit finished = 1'b0;

  logic [N-1:0] mWr [N];
  logic [N-1:0] mRd [N];

  always #2 clk = ~clk;

  fu_dep_matrix #(.NUM_UNITS(N)) u_fu_dep_matrix (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueUnit(issueUnit),
    .pendWriteVec(pendWriteVec), .pendReadVec(pendReadVec), .goClear(goClear),
    .readable(readable), .writable(writable)
  );

  function automatic logic [N-1:0] expRead();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (mWr[i] == '0);
    return v;
  endfunction

  function automatic logic [N-1:0] expWrite();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (mRd[i] == '0);
    return v;
  endfunction

  task automatic check(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < N; i++) begin mWr[i] = '0; mRd[i] = '0; end
  endtask

  // Model per R2..R9, R11: accepted issue loads its row without self bit and
  // without columns being cleared; cleared rows empty; others lose cleared columns.
  task automatic modelStep(input logic iv, input logic [N-1:0] iu, input logic [N-1:0] pw,
                           input logic [N-1:0] pr, input logic [N-1:0] gc);
    bit ok;
    ok = iv && ($countones(iu) == 1);
    for (int i = 0; i < N; i++) begin
      if (ok && iu[i]) begin
        mWr[i] = pw & ~iu & ~gc;
        mRd[i] = pr & ~iu & ~gc;
      end else if (gc[i]) begin
        mWr[i] = '0;
        mRd[i] = '0;
      end else begin
        mWr[i] = mWr[i] & ~gc;
        mRd[i] = mRd[i] & ~gc;
      end
    end
  endtask

  // Drives inputs just after an edge, checks R10 before the next edge, then the result after it.
  task automatic step(input string tag, input logic iv, input logic [N-1:0] iu, input logic [N-1:0] pw,
                      input logic [N-1:0] pr, input logic [N-1:0] gc);
    issueValid = iv; issueUnit = iu; pendWriteVec = pw; pendReadVec = pr; goClear = gc;
    #1;
    check("R10", "readable before edge", readable, expRead());
    check("R10", "writable before edge", writable, expWrite());
    @(posedge clk);
    modelStep(iv, iu, pw, pr, gc);
    #1;
    check(tag, "readable", readable, expRead());
    check(tag, "writable", writable, expWrite());
  endtask

  function automatic logic [N-1:0] bitOf(input int k);
    return N'(1) << k;
  endfunction

  initial begin
    #(4 * 190000);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelClear();
    repeat (3) @(posedge clk);
    #1;
    check("R1", "readable in reset", readable, '1);
    check("R1", "writable in reset", writable, '1);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1", "readable after reset", readable, '1);
    check("R1", "writable after reset", writable, '1);

    step("R2", 1'b1, bitOf(0), '0, '0, '0);                       // unit0 no deps
    step("R2", 1'b1, bitOf(1), bitOf(0), '0, '0);                 // unit1 waits to read on 0
    step("R3", 1'b1, bitOf(2), '0, bitOf(0) | bitOf(1), '0);      // unit2 waits to write on 0,1
    step("R4", 1'b1, bitOf(3), bitOf(3), bitOf(3), '0);           // self bits ignored
    step("R10", 1'b1, bitOf(4), bitOf(0), '0, '0);                // change only after edge
    step("R5", 1'b0, '0, '0, '0, bitOf(0));                       // column 0 cleared
    step("R6", 1'b1, bitOf(5), bitOf(1), bitOf(2), '0);
    step("R6", 1'b0, '0, '0, '0, bitOf(5));                       // row 5 wiped
    step("R7", 1'b1, bitOf(6), bitOf(1) | bitOf(4), bitOf(1), bitOf(1)); // edge to 1 dropped
    step("R6", 1'b1, bitOf(7), bitOf(6), bitOf(6), bitOf(7));     // issue wins over own clear
    step("R8", 1'b1, bitOf(0) | bitOf(3), '1, '1, '0);            // two bits: ignored
    step("R8", 1'b1, '0, '1, '1, '0);                             // zero bits: ignored
    step("R9", 1'b0, '0, '1, '1, '0);                             // idle holds
    step("R11", 1'b0, '0, '0, '0, bitOf(4) | bitOf(6) | bitOf(7));
    step("R11", 1'b0, '0, '0, '0, '1);

    for (int n = 0; n < 600; n++) begin
      logic         iv;
      logic [N-1:0] iu, pw, pr, gc;
      iv = ($urandom_range(0, 9) < 6);
      if ($urandom_range(0, 9) < 8) iu = bitOf($urandom_range(0, N - 1));
      else iu = N'($urandom);
      pw = N'($urandom) & N'($urandom);
      pr = N'($urandom) & N'($urandom);
      case ($urandom_range(0, 9))
        0, 1, 2: gc = bitOf($urandom_range(0, N - 1));
        3:       gc = N'($urandom) & N'($urandom);
        4:       gc = iu;
        default: gc = '0;
      endcase
      step("R9", iv, iu, pw, pr, gc);
    end

    rstN = 1'b0;
    @(posedge clk);
    modelClear();
    #1;
    check("R1", "readable on reapplied reset", readable, '1);
    check("R1", "writable on reapplied reset", writable, '1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule